// File: doc/BRIEF.md
# Bidirectional Stepper Phase Driver

This block steers a reversible two-coil stepper motor through four phase lines, named here A, A-bar, B and B-bar. A processor hands over commands one at a time on a valid/ready port. Each command asks for a step, a hold or a rest, and a step command also carries a direction. An accepted command is held in a one-entry slot. It takes effect only when a separate stepper clock strobe arrives. That strobe commits the new phase pattern onto the lines, so the motor sees quadrature waveforms at the strobe rate.

Stepping walks a four-entry full-step table. Clockwise moves forward through the table and counterclockwise moves backward. A rest command opens every coil by driving all four lines to zero. The table position is kept while the motor rests, so the next step carries on from where the motor stopped.

Back-pressure works as follows. `cmd_ready` is high when the slot is empty, or when a strobe in the same cycle is consuming the held command. A command is accepted on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. While a command waits for its strobe, the port stalls the processor. All signals are synchronous to `clk`, and reset is asynchronous and active low.

Top module: `stepper_phase_drv`

## Requirements
- R1: While reset is asserted and right after it, `phase` is 4'b0000, `cmd_ready` is 1 and the table index is 0, so a hold as the first command drives 4'b1010.
- R2: An accepted command stays pending until a strobe arrives. While it is pending and no strobe is present, `cmd_ready` is 0 and further commands are refused.
- R3: `phase` changes only on the clock edge after a cycle in which `stb` is high while a command is pending. The output is registered, so the change shows one cycle after that strobe.
- R4: A step command with `cmd_dir`=1 (clockwise) and `cmd_rest`=0 advances the index by one. The index selects {A,A-bar,B,B-bar} in the order 1010, 0110, 0101, 1001, wrapping back to 1010.
- R5: A step command with `cmd_dir`=0 (counterclockwise) walks the same table in reverse: 1010, 1001, 0101, 0110, then 1010.
- R6: A command with `cmd_rest`=1 drives `phase` to 4'b0000 at its strobe and leaves the index unchanged, even if `cmd_step` is also 1.
- R7: The first step after a rest moves one table entry away from the index held before the rest.
- R8: Each strobe moves the pattern by at most one table entry. Between two energized outputs, at most one coil pair changes.
- R9: Every energized output has exactly one line of the pair {A,A-bar} high and exactly one line of the pair {B,B-bar} high.
- R10: A command with `cmd_step`=0 and `cmd_rest`=0 drives the pattern of the current index without moving the index.
- R11: A strobe with no pending command leaves `phase` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered by the processor |
| cmd_ready | output | 1 | Slot can take a command this cycle |
| cmd_step | input | 1 | 1 = advance one table entry, 0 = hold the current entry |
| cmd_dir | input | 1 | 1 = clockwise, 0 = counterclockwise |
| cmd_rest | input | 1 | 1 = open all coils (takes priority over a step) |
| stb | input | 1 | Stepper clock strobe that commits the pending command |
| phase | output | 4 | Coil lines {A, A-bar, B, B-bar} |

## Verification
Some properties are checked by assertions on every cycle. They cover the stall while a command waits for its strobe, outputs that change only after a consuming strobe, the one-line-per-pair shape of every energized pattern, at most one coil pair flipping per strobe, and the zero output after a rest. Other behaviour only the bench scenarios can show: the exact clockwise and counterclockwise orders, including wrap-around in both directions, resuming from the held index after a rest, a rest that wins over a simultaneous step, and the index clearing on a reset in the middle of a run.

// File: rtl/stp_pkg.sv
package stp_pkg;
  localparam int unsigned NUM_LINES  = 4;
  localparam int unsigned NUM_STATES = 4;
  localparam int unsigned IDX_W      = $clog2(NUM_STATES);

  typedef logic [IDX_W-1:0]     idx_t;
  typedef logic [NUM_LINES-1:0] lines_t;

  typedef struct packed {
    logic step;
    logic dir;
    logic rest;
  } stp_cmd_t;

  // Full-step pattern {A, A-bar, B, B-bar} for a table index.
  // A is high where both index bits agree; B is high in the lower half.
  function automatic lines_t full_step_pattern(idx_t idx);
    logic a_on;
    logic b_on;
    a_on = (idx[1] == idx[0]);
    b_on = ~idx[1];
    return {a_on, ~a_on, b_on, ~b_on};
  endfunction
endpackage

// File: rtl/stp_cmd_slot.sv
module stp_cmd_slot
  import stp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  input  stp_cmd_t in_cmd,
  input  logic     stb,
  output logic     fire,
  output stp_cmd_t held_cmd
);
  logic held_vld;

  assign fire     = stb & held_vld;
  assign in_ready = ~held_vld | stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_vld <= 1'b0;
      held_cmd <= '0;
    end else if (in_valid && in_ready) begin
      held_vld <= 1'b1;
      held_cmd <= in_cmd;
    end else if (fire) begin
      held_vld <= 1'b0;
    end
  end

  assert_pending_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (held_vld && !stb) |=> (held_vld && $stable(held_cmd)));

  assert_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (held_vld && !stb) |-> !in_ready);
endmodule

// File: rtl/stp_phase_seq.sv
module stp_phase_seq
  import stp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fire,
  input  stp_cmd_t cmd,
  output idx_t     idx_nxt
);
  idx_t idx_q;
  logic move;

  assign move = fire && cmd.step && !cmd.rest;

  always_comb begin
    idx_nxt = idx_q;
    if (move) begin
      if (cmd.dir) idx_nxt = idx_q + idx_t'(1);
      else         idx_nxt = idx_q - idx_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_nxt;
  end

  assert_idx_only_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(idx_q));

  assert_rest_keeps_idx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd.rest) |=> $stable(idx_q));
endmodule

// File: rtl/stp_coil_out.sv
module stp_coil_out
  import stp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   fire,
  input  logic   rest,
  input  idx_t   idx_nxt,
  output lines_t phase
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (fire) phase <= rest ? '0 : full_step_pattern(idx_nxt);
  end

  assert_rest_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && rest) |=> (phase == '0));

  assert_no_change_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(phase));

  assert_pair_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != '0) |-> ((phase[3] ^ phase[2]) && (phase[1] ^ phase[0])));

  assert_one_coil_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != '0 && $past(phase) != '0) |-> ($countones(phase ^ $past(phase)) <= 2));
endmodule

// File: rtl/stepper_phase_drv.sv
module stepper_phase_drv
  import stp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic       cmd_step,
  input  logic       cmd_dir,
  input  logic       cmd_rest,
  input  logic       stb,
  output logic [3:0] phase
);
  stp_cmd_t in_cmd;
  stp_cmd_t held_cmd;
  logic     fire;
  idx_t     idx_nxt;
  lines_t   phase_w;

  assign in_cmd = '{step: cmd_step, dir: cmd_dir, rest: cmd_rest};

  stp_cmd_slot u_slot (
    .clk(clk), .rst_n(rst_n),
    .in_valid(cmd_valid), .in_ready(cmd_ready), .in_cmd(in_cmd),
    .stb(stb), .fire(fire), .held_cmd(held_cmd)
  );

  stp_phase_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .fire(fire), .cmd(held_cmd), .idx_nxt(idx_nxt)
  );

  stp_coil_out u_out (
    .clk(clk), .rst_n(rst_n),
    .fire(fire), .rest(held_cmd.rest), .idx_nxt(idx_nxt), .phase(phase_w)
  );

  assign phase = phase_w;

  assert_change_needs_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase) |-> $past(stb));
endmodule

// File: tb/sim_stepper_phase_drv.sv
module sim_stepper_phase_drv;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_step = 1'b0, cmd_dir = 1'b0, cmd_rest = 1'b0, stb = 1'b0;
  logic cmd_ready;
  logic [3:0] phase;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stepper_phase_drv u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_step(cmd_step), .cmd_dir(cmd_dir), .cmd_rest(cmd_rest),
    .stb(stb), .phase(phase)
  );

  // {step, dir, rest, expected phase, requirement id}
  typedef struct packed {
    logic       step;
    logic       dir;
    logic       rest;
    logic [3:0] exp;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 4'b1010, 8'd10}, // R10 hold at index 0
    '{1'b1, 1'b1, 1'b0, 4'b0110, 8'd4},  // R4
    '{1'b1, 1'b1, 1'b0, 4'b0101, 8'd4},
    '{1'b1, 1'b1, 1'b0, 4'b1001, 8'd4},
    '{1'b1, 1'b1, 1'b0, 4'b1010, 8'd4},  // R4 wrap
    '{1'b1, 1'b0, 1'b0, 4'b1001, 8'd5},  // R5 wrap back
    '{1'b1, 1'b0, 1'b0, 4'b0101, 8'd5},
    '{1'b0, 1'b0, 1'b1, 4'b0000, 8'd6},  // R6 rest at index 2
    '{1'b1, 1'b1, 1'b0, 4'b1001, 8'd7},  // R7 resume to index 3
    '{1'b1, 1'b1, 1'b1, 4'b0000, 8'd6},  // R6 rest wins over step
    '{1'b1, 1'b0, 1'b0, 4'b0101, 8'd7},  // R7 resume from 3 ccw
    '{1'b1, 1'b0, 1'b0, 4'b0110, 8'd5},
    '{1'b1, 1'b0, 1'b0, 4'b1010, 8'd5},
    '{1'b1, 1'b0, 1'b0, 4'b1001, 8'd5}
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic send(input logic s, input logic d, input logic r);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_step = s; cmd_dir = d; cmd_rest = r;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Called at a negedge; the phase update lands at the next posedge.
  task automatic strobe();
    stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 phase in reset", phase, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 phase after reset", phase, 4'b0000);
    check("R1 ready after reset", {3'b0, cmd_ready}, 4'b0001);

    for (int i = 0; i < NV; i++) begin
      send(VECS[i].step, VECS[i].dir, VECS[i].rest);
      strobe();
      check($sformatf("R%0d vector %0d", VECS[i].req, i), phase, VECS[i].exp);
    end
    // now at index 3, 1001

    // R2 / R3: a pending command with no strobe does not move the output
    send(1'b1, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    check("R3 no strobe no change", phase, 4'b1001);
    check("R2 ready low while pending", {3'b0, cmd_ready}, 4'b0000);
    // R2: a second offer is refused while the slot is full
    cmd_valid = 1'b1; cmd_step = 1'b1; cmd_dir = 1'b0; cmd_rest = 1'b1;
    repeat (2) @(negedge clk);
    cmd_valid = 1'b0;
    strobe();
    check("R2 held command committed", phase, 4'b1010);
    check("R2 refused command not taken", {3'b0, cmd_ready}, 4'b0001);

    // R11: strobe without a pending command
    strobe();
    check("R11 idle strobe", phase, 4'b1010);
    strobe();
    check("R11 idle strobe again", phase, 4'b1010);

    // R1: reset mid-run clears the index
    send(1'b1, 1'b1, 1'b0);
    strobe();
    check("R4 pre-reset step", phase, 4'b0110);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset opens coils", phase, 4'b0000);
    rst_n = 1'b1;
    send(1'b0, 1'b1, 1'b0);
    strobe();
    check("R1 index cleared by reset", phase, 4'b1010);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule